// File: doc/BRIEF.md
# Board Configuration Command Controller

This block turns three bus-visible registers into a small command engine for board configuration. Software first places an operand in the data register, then writes a command word to the control register with its launch bit set. In the same write the controller splits the word into controller number, function, site, stack position and device index, checks that the combination is one it serves, and carries it out. A read fetches an oscillator frequency or a fixed voltage reading into the data register. A write updates an oscillator entry, or raises a one-cycle power-off or restart request. The status register then shows completion, plus an error flag when the command was refused.

The oscillator and voltage tables hold numbers only; no clock or sensor hardware sits behind them. The daughter-board table sizes and contents are parameters. The main board always has six oscillator entries, one voltage reading and the power and video controls.

Top module: `cfg_txn_ctrl`

## Requirements
- R1: After reset, the data (address 0), control (address 1) and status (address 2) registers read 0, address 3 reads 0, and both request outputs are low.
- R2: The control register returns the last word written to it, with bit 31 (launch) and bits 19:18 always reading 0.
- R3: A control write with bit 31 set executes at that clock edge. From the next cycle, status bit 0 (done) reads 1 and status bit 1 (error) reads 1 only if the command was refused. Command fields: bit 30 write (1) or read (0), bits 29:26 controller, bits 25:20 function, bits 17:16 site, bits 15:12 position, bits 11:0 device.
- R4: A command whose controller or position field is nonzero, or whose site is neither 0 (main) nor 1 (daughter), is refused (status 3), and the data register keeps its value.
- R5: Function 1 on site 0 reads or writes main-board oscillator entries 0 to 5, which reset to 50000000, 23750000, 24000000, 24000000, 24000000, 24000000. A write stores the data register contents, and a read loads the entry into the data register.
- R6: Function 1 on site 1 reads or writes the daughter-board oscillator entries (count and reset values are parameters). A device index at or beyond the count is refused.
- R7: Function 2 reads voltages. Site 0 device 0 returns 3300000, and site 1 returns the parameterised value for each device below the voltage count. Voltage writes, and devices out of range, are refused.
- R8: A write of function 8 (power-off) or function 9 (restart) to site 0 device 0 drives `poweroff_req` or `reboot_req` high for exactly the one cycle after the command edge. A read of these functions, or any other site or device, is refused and produces no pulse.
- R9: A write of function 7 (video source) or function 11 (display mode) to site 0 device 0 completes with status 1 and changes neither the data register nor the request outputs.
- R10: A write to the status register keeps only its low two bits.
- R11: A control write with bit 31 clear changes neither the status nor the data register.
- R12: Function codes other than 1, 2, 7, 8, 9 and 11 are refused with status 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| poweroff_req | output | 1 | One-cycle power-off request |
| reboot_req | output | 1 | One-cycle restart request |

## Verification
The request pulse of a power-off or restart command is still high in the cycle where a second command, issued back to back, is decoded and executes. The bench provokes this with a restart command followed in the very next cycle by an oscillator read. It also issues power commands in a row. A behavioural model compares the read data and both request lines in every cycle, and so judges that the pulse lasts exactly one cycle. It also checks that the second command's result and status replace the first's.

// File: rtl/cfgc_pkg.sv
`timescale 1ns/1ps
package cfgc_pkg;

  // register select codes
  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  // function codes
  localparam logic [5:0] FN_OSC  = 6'd1;
  localparam logic [5:0] FN_VOLT = 6'd2;
  localparam logic [5:0] FN_VSRC = 6'd7;
  localparam logic [5:0] FN_OFF  = 6'd8;
  localparam logic [5:0] FN_RBT  = 6'd9;
  localparam logic [5:0] FN_DISP = 6'd11;

  localparam logic [1:0] SITE_MAIN = 2'd0;
  localparam logic [1:0] SITE_DTR  = 2'd1;

  localparam logic [31:0] MAIN_VOLT_UV = 32'd3300000;
  localparam logic [31:0] CTRL_DROP    = 32'h800C_0000;

  typedef struct packed {
    logic        launch;
    logic        is_wr;
    logic [3:0]  ctl;
    logic [5:0]  fn;
    logic [1:0]  rsv;
    logic [1:0]  site;
    logic [3:0]  pos;
    logic [11:0] dev;
  } cfg_word_t;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_OSC_MAIN, ACT_OSC_DTR, ACT_VOLT_MAIN,
    ACT_VOLT_DTR, ACT_OFF, ACT_RBT, ACT_NOP
  } act_e;

  function automatic logic [31:0] main_osc_reset(int idx);
    case (idx)
      0:       return 32'd50000000;
      1:       return 32'd23750000;
      default: return 32'd24000000;
    endcase
  endfunction

  function automatic logic [31:0] ctrl_keep(logic [31:0] w);
    return w & ~CTRL_DROP;
  endfunction

  function automatic logic route_ok(logic [3:0] ctl, logic [3:0] pos, logic [1:0] site);
    return (ctl == 4'd0) && (pos == 4'd0) && (site == SITE_MAIN || site == SITE_DTR);
  endfunction

  function automatic logic [1:0] stat_code(logic ok);
    return {~ok, 1'b1};
  endfunction

endpackage

// File: rtl/cfgc_decode.sv
`timescale 1ns/1ps
module cfgc_decode
  import cfgc_pkg::*;
#(
  parameter int MB_OSC_N  = 6,
  parameter int DB_OSC_N  = 2,
  parameter int DB_VOLT_N = 2
) (
  input  logic        is_wr,
  input  logic [3:0]  ctl,
  input  logic [5:0]  fn,
  input  logic [1:0]  site,
  input  logic [3:0]  pos,
  input  logic [11:0] dev,
  output act_e        act,
  output logic        ok
);
  logic main_s, dtr_s, dev0;

  always_comb begin
    main_s = (site == SITE_MAIN);
    dtr_s  = (site == SITE_DTR);
    dev0   = (dev == 12'd0);
    act    = ACT_NONE;
    if (route_ok(ctl, pos, site)) begin
      case (fn)
        FN_OSC: begin
          if (main_s && int'(dev) < MB_OSC_N)      act = ACT_OSC_MAIN;
          else if (dtr_s && int'(dev) < DB_OSC_N)  act = ACT_OSC_DTR;
        end
        FN_VOLT: begin
          if (!is_wr) begin
            if (main_s && dev0)                       act = ACT_VOLT_MAIN;
            else if (dtr_s && int'(dev) < DB_VOLT_N)  act = ACT_VOLT_DTR;
          end
        end
        FN_OFF:  if (is_wr && main_s && dev0) act = ACT_OFF;
        FN_RBT:  if (is_wr && main_s && dev0) act = ACT_RBT;
        FN_VSRC, FN_DISP: if (is_wr && main_s && dev0) act = ACT_NOP;
        default: act = ACT_NONE;
      endcase
    end
    ok = (act != ACT_NONE);
  end
endmodule

// File: rtl/cfgc_osc_bank.sv
`timescale 1ns/1ps
module cfgc_osc_bank #(
  parameter int             N   = 2,
  parameter int             IW  = 12,
  parameter logic [N*32-1:0] RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [31:0]   wval,
  output logic [31:0]   rval
);
  logic [N*32-1:0] flat;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [31:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     q <= RST[g*32 +: 32];
      else if (we && int'(idx) == g)  q <= wval;
    end
    assign flat[g*32 +: 32] = q;
  end

  always_comb begin
    rval = '0;
    for (int i = 0; i < N; i++)
      if (int'(idx) == i) rval = flat[i*32 +: 32];
  end

  // entries only move on an accepted oscillator write (R5, R6)
  p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flat));
endmodule

// File: rtl/cfgc_volt_rom.sv
`timescale 1ns/1ps
module cfgc_volt_rom #(
  parameter int              N    = 2,
  parameter int              IW   = 12,
  parameter logic [N*32-1:0] VALS = '0
) (
  input  logic [IW-1:0] idx,
  output logic [31:0]   val
);
  always_comb begin
    val = '0;
    for (int i = 0; i < N; i++)
      if (int'(idx) == i) val = VALS[i*32 +: 32];
  end
endmodule

// File: rtl/cfg_txn_ctrl.sv
`timescale 1ns/1ps
module cfg_txn_ctrl
  import cfgc_pkg::*;
#(
  parameter int                      MB_OSC_N    = 6,
  parameter int                      DB_OSC_N    = 2,
  parameter logic [DB_OSC_N*32-1:0]  DB_OSC_RST  = {32'd40000000, 32'd60000000},
  parameter int                      DB_VOLT_N   = 2,
  parameter logic [DB_VOLT_N*32-1:0] DB_VOLT_VAL = {32'd1800000, 32'd900000}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        poweroff_req,
  output logic        reboot_req
);
  localparam int DEV_W = 12;

  function automatic logic [MB_OSC_N*32-1:0] main_rst_pack();
    logic [MB_OSC_N*32-1:0] r;
    r = '0;
    for (int i = 0; i < MB_OSC_N; i++) r[i*32 +: 32] = main_osc_reset(i);
    return r;
  endfunction

  localparam logic [MB_OSC_N*32-1:0] MB_RST = main_rst_pack();

  cfg_word_t   cmd;
  logic        data_wr, ctrl_wr, stat_wr, start_fire;
  act_e        act;
  logic        cmd_ok, rd_load, main_we, dtr_we;
  logic [31:0] main_rd, dtr_rd, volt_rd, rd_val;
  logic [31:0] data_q, ctrl_q;
  logic [1:0]  stat_q;
  logic        off_q, rbt_q;

  assign cmd        = cfg_word_t'(bus_wdata);
  assign data_wr    = bus_wr && (bus_addr == REG_DATA);
  assign ctrl_wr    = bus_wr && (bus_addr == REG_CTRL);
  assign stat_wr    = bus_wr && (bus_addr == REG_STAT);
  assign start_fire = ctrl_wr && cmd.launch;

  cfgc_decode #(.MB_OSC_N(MB_OSC_N), .DB_OSC_N(DB_OSC_N), .DB_VOLT_N(DB_VOLT_N)) u_dec (
    .is_wr(cmd.is_wr), .ctl(cmd.ctl), .fn(cmd.fn), .site(cmd.site),
    .pos(cmd.pos), .dev(cmd.dev), .act(act), .ok(cmd_ok)
  );

  assign main_we = start_fire && cmd.is_wr && (act == ACT_OSC_MAIN);
  assign dtr_we  = start_fire && cmd.is_wr && (act == ACT_OSC_DTR);
  assign rd_load = start_fire && !cmd.is_wr && cmd_ok;

  cfgc_osc_bank #(.N(MB_OSC_N), .IW(DEV_W), .RST(MB_RST)) u_main_osc (
    .clk(clk), .rst_n(rst_n), .we(main_we), .idx(cmd.dev), .wval(data_q), .rval(main_rd)
  );

  cfgc_osc_bank #(.N(DB_OSC_N), .IW(DEV_W), .RST(DB_OSC_RST)) u_dtr_osc (
    .clk(clk), .rst_n(rst_n), .we(dtr_we), .idx(cmd.dev), .wval(data_q), .rval(dtr_rd)
  );

  cfgc_volt_rom #(.N(DB_VOLT_N), .IW(DEV_W), .VALS(DB_VOLT_VAL)) u_volt (
    .idx(cmd.dev), .val(volt_rd)
  );

  always_comb begin
    case (act)
      ACT_OSC_MAIN:  rd_val = main_rd;
      ACT_OSC_DTR:   rd_val = dtr_rd;
      ACT_VOLT_MAIN: rd_val = MAIN_VOLT_UV;
      ACT_VOLT_DTR:  rd_val = volt_rd;
      default:       rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
      off_q  <= 1'b0;
      rbt_q  <= 1'b0;
    end else begin
      if (data_wr)      data_q <= bus_wdata;
      else if (rd_load) data_q <= rd_val;
      if (ctrl_wr)      ctrl_q <= ctrl_keep(cmd);
      if (stat_wr)         stat_q <= bus_wdata[1:0];
      else if (start_fire) stat_q <= stat_code(cmd_ok);
      off_q <= start_fire && (act == ACT_OFF);
      rbt_q <= start_fire && (act == ACT_RBT);
    end
  end

  always_comb begin
    case (bus_addr)
      REG_DATA: bus_rdata = data_q;
      REG_CTRL: bus_rdata = ctrl_q;
      REG_STAT: bus_rdata = {30'd0, stat_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign poweroff_req = off_q;
  assign reboot_req   = rbt_q;

  p_ctrl_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_CTRL) |-> (bus_rdata[31] == 1'b0 && bus_rdata[19:18] == 2'b00));
  p_done_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> stat_q[0]);
  p_refuse_flags_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_fire && !cmd_ok) |=> (stat_q == 2'b11));
  p_req_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({poweroff_req, reboot_req}));
  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_fire && !data_wr) |=> $stable(data_q));
endmodule

// File: tb/sim_cfg_txn_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_txn_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        poweroff_req, reboot_req;

  always #2.5 clk = ~clk;

  cfg_txn_ctrl #(
    .MB_OSC_N(6), .DB_OSC_N(2), .DB_OSC_RST({32'd40000000, 32'd60000000}),
    .DB_VOLT_N(2), .DB_VOLT_VAL({32'd1800000, 32'd900000})
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .poweroff_req(poweroff_req), .reboot_req(reboot_req)
  );

  int total = 0;
  int bad = 0;

  // behavioural reference state
  int unsigned m_main [6];
  int unsigned m_dtr [2];
  int unsigned m_vlt [2];
  logic [31:0] m_data = '0, m_ctrl = '0;
  logic [1:0]  m_stat = '0;
  logic        pend_off = 1'b0, pend_rb = 1'b0;
  logic [31:0] s_data = '0, s_ctrl = '0;
  logic [1:0]  s_stat = '0;
  logic        e_off = 1'b0, e_rb = 1'b0;

  initial begin
    m_main = '{50000000, 23750000, 24000000, 24000000, 24000000, 24000000};
    m_dtr  = '{60000000, 40000000};
    m_vlt  = '{900000, 1800000};
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] snap(logic [1:0] a);
    case (a)
      2'd0: return s_data;
      2'd1: return s_ctrl;
      2'd2: return {30'd0, s_stat};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_cmd(logic [31:0] w);
    int c = int'((w >> 26) & 32'hF);
    int f = int'((w >> 20) & 32'h3F);
    int s = int'((w >> 16) & 32'h3);
    int p = int'((w >> 12) & 32'hF);
    int d = int'(w & 32'hFFF);
    bit wr = w[30];
    bit ok = 0;
    logic [31:0] res = '0;
    if (c == 0 && p == 0 && s < 2) begin
      case (f)
        1: if (s == 0 && d < 6) begin
             ok = 1; if (wr) m_main[d] = m_data; else res = m_main[d];
           end else if (s == 1 && d < 2) begin
             ok = 1; if (wr) m_dtr[d] = m_data; else res = m_dtr[d];
           end
        2: if (!wr) begin
             if (s == 0 && d == 0) begin ok = 1; res = 32'd3300000; end
             else if (s == 1 && d < 2) begin ok = 1; res = m_vlt[d]; end
           end
        7, 11: if (wr && s == 0 && d == 0) ok = 1;
        8: if (wr && s == 0 && d == 0) begin ok = 1; pend_off = 1'b1; end
        9: if (wr && s == 0 && d == 0) begin ok = 1; pend_rb = 1'b1; end
        default: ok = 0;
      endcase
    end
    m_stat = ok ? 2'b01 : 2'b11;
    if (ok && !wr) m_data = res;
  endtask

  // called and returning at a falling edge
  task automatic wr(logic [1:0] a, logic [31:0] v);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    case (a)
      2'd0: m_data = v;
      2'd1: begin m_ctrl = v & 32'h7FF3_FFFF; if (v[31]) model_cmd(v); end
      2'd2: m_stat = v[1:0];
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; pend_off = 1'b0; pend_rb = 1'b0;
  endtask

  task automatic rdchk(string tag, logic [1:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic pulsechk(string tag, logic eo, logic er);
    #1;
    chk({tag, " poweroff"}, {31'd0, poweroff_req}, {31'd0, eo});
    chk({tag, " reboot"}, {31'd0, reboot_req}, {31'd0, er});
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      s_data <= '0; s_ctrl <= '0; s_stat <= '0; e_off <= 1'b0; e_rb <= 1'b0;
    end else begin
      s_data <= m_data; s_ctrl <= m_ctrl; s_stat <= m_stat;
      e_off <= pend_off; e_rb <= pend_rb;
    end
  end

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      chk("R3 per-cycle rdata", bus_rdata, snap(bus_addr));
      chk("R8 per-cycle poweroff", {31'd0, poweroff_req}, {31'd0, e_off});
      chk("R8 per-cycle reboot", {31'd0, reboot_req}, {31'd0, e_rb});
    end
  end

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdchk("R1 data", 2'd0, 32'd0);
    rdchk("R1 ctrl", 2'd1, 32'd0);
    rdchk("R1 stat", 2'd2, 32'd0);
    rdchk("R1 addr3", 2'd3, 32'd0);
    pulsechk("R1", 1'b0, 1'b0);

    // R2 / R11 control write without launch
    wr(2'd0, 32'hA5A5_0001);
    wr(2'd1, 32'h7FFF_FFFF);
    rdchk("R2 ctrl masked", 2'd1, 32'h7FF3_FFFF);
    rdchk("R11 stat unchanged", 2'd2, 32'd0);
    rdchk("R11 data unchanged", 2'd0, 32'hA5A5_0001);

    // R5 main oscillator reset values
    for (int d = 0; d < 6; d++) begin
      wr(2'd1, 32'h8010_0000 | d);
      rdchk("R5 main osc read", 2'd0, (d == 0) ? 32'd50000000 : (d == 1) ? 32'd23750000 : 32'd24000000);
      rdchk("R3 done", 2'd2, 32'd1);
    end
    wr(2'd0, 32'h1234_5678);
    wr(2'd1, 32'hC010_0002);
    rdchk("R2 launch reads 0", 2'd1, 32'h4010_0002);
    rdchk("R3 write done", 2'd2, 32'd1);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h8010_0002);
    rdchk("R5 main osc writeback", 2'd0, 32'h1234_5678);
    wr(2'd1, 32'h8010_0006);
    rdchk("R5 main osc dev6 err", 2'd2, 32'd3);

    // R6 daughter oscillators
    wr(2'd1, 32'h8011_0000);
    rdchk("R6 dtr osc0", 2'd0, 32'd60000000);
    wr(2'd1, 32'h8011_0001);
    rdchk("R6 dtr osc1", 2'd0, 32'd40000000);
    wr(2'd1, 32'h8011_0002);
    rdchk("R6 dtr dev2 err", 2'd2, 32'd3);
    rdchk("R6 dtr dev2 data kept", 2'd0, 32'd40000000);
    wr(2'd0, 32'd777);
    wr(2'd1, 32'hC011_0001);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h8011_0001);
    rdchk("R6 dtr osc1 writeback", 2'd0, 32'd777);

    // R7 voltages
    wr(2'd1, 32'h8020_0000);
    rdchk("R7 main volt", 2'd0, 32'd3300000);
    wr(2'd1, 32'h8021_0001);
    rdchk("R7 dtr volt1", 2'd0, 32'd1800000);
    wr(2'd1, 32'hC020_0000);
    rdchk("R7 volt write err", 2'd2, 32'd3);
    wr(2'd1, 32'h8020_0001);
    rdchk("R7 main volt dev1 err", 2'd2, 32'd3);
    wr(2'd1, 32'h8021_0002);
    rdchk("R7 dtr volt dev2 err", 2'd2, 32'd3);

    // R4 routing refusals
    wr(2'd1, 32'h8410_0000);
    rdchk("R4 ctl nonzero", 2'd2, 32'd3);
    wr(2'd1, 32'h8010_1000);
    rdchk("R4 pos nonzero", 2'd2, 32'd3);
    wr(2'd1, 32'h8012_0000);
    rdchk("R4 site 2", 2'd2, 32'd3);
    rdchk("R4 data kept", 2'd0, 32'd1800000);

    // R8 power requests
    wr(2'd1, 32'hC080_0000);
    pulsechk("R8 off pulse", 1'b1, 1'b0);
    pulsechk("R8 off ends", 1'b0, 1'b0);
    wr(2'd1, 32'hC090_0000);
    pulsechk("R8 reboot pulse", 1'b0, 1'b1);
    pulsechk("R8 reboot ends", 1'b0, 1'b0);
    wr(2'd1, 32'h8080_0000);
    pulsechk("R8 read no pulse", 1'b0, 1'b0);
    rdchk("R8 read err", 2'd2, 32'd3);
    wr(2'd1, 32'hC091_0000);
    pulsechk("R8 site1 no pulse", 1'b0, 1'b0);
    rdchk("R8 site1 err", 2'd2, 32'd3);

    // collision: pulse of one command while the next executes
    wr(2'd1, 32'hC090_0000);
    wr(2'd1, 32'h8010_0002);
    pulsechk("R8 back-to-back end", 1'b0, 1'b0);
    rdchk("R8 back-to-back data", 2'd0, 32'h1234_5678);
    wr(2'd1, 32'hC080_0000);
    wr(2'd1, 32'hC080_0000);
    pulsechk("R8 repeated off", 1'b1, 1'b0);

    // R9 accepted no-op functions
    wr(2'd0, 32'hDEAD_0009);
    wr(2'd1, 32'hC070_0000);
    pulsechk("R9 video no pulse", 1'b0, 1'b0);
    rdchk("R9 video ok", 2'd2, 32'd1);
    wr(2'd1, 32'hC0B0_0000);
    rdchk("R9 display ok", 2'd2, 32'd1);
    rdchk("R9 data kept", 2'd0, 32'hDEAD_0009);

    // R10 status write
    wr(2'd2, 32'hFFFF_FFFE);
    rdchk("R10 stat low bits", 2'd2, 32'd2);

    // R12 unknown function
    wr(2'd1, 32'h8050_0000);
    rdchk("R12 fn5 err", 2'd2, 32'd3);
    wr(2'd1, 32'hC3F0_0000);
    rdchk("R12 fn63 err", 2'd2, 32'd3);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule